// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block sends two channels of captured audio out on one serial data line. Framing can be left-justified, right-justified, I2S, DSP or TDM. A single system clock `clk` drives every register. The bit clock and word clock arrive as strobes and levels in that clock domain. `bit_lead` marks the start of each bit cycle and `bit_mid` marks its middle. The word clock level `wclk` is sampled on each `bit_lead`.

A sample pair comes in over a valid/ready port and waits in a holding register. At the next frame start it moves into a shadow register, and the shadow register is the only source of serial data for that frame. Each of the two transmit slots begins at a position set in bit clocks. Either slot can be turned off. The data line can be released to high impedance after the LSB of a slot, or half a bit early, so that several transmitters can share a TDM bus. A filter-sync pulse marks the start of the earliest slot that is enabled.

The input port follows these back-pressure rules. `s_ready` is high while the holding register is empty. A transfer happens on a clock edge where `s_valid` and `s_ready` are both high. After that, `s_ready` stays low until the next frame start empties the holding register. If no new pair has arrived by a frame start, the shadow keeps its previous contents and that pair is sent again.

Top module: `audio_serial_tx`

## Requirements
- R1: Every slot is sent MSB first. The sample word is left-aligned in 32 bits, so bit 31 goes out first. `cfg_wlen` sets the word length: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits.
- R2: Bit 0 of a frame is the bit cycle that starts at a `bit_lead` on which `wclk` is sampled high after being sampled low on the previous `bit_lead`. `cfg_fmt` selects the format: 0 = left-justified, 1 = right-justified, 2 = I2S, 3 = DSP, 4 = TDM. The first slot starts at bit `cfg_off1` in left-justified, DSP and TDM, and at bit `cfg_off1`+1 in I2S.
- R3: With `cfg_slot_mode` = 0, the second slot starts half a frame after the first slot in left-justified, right-justified and I2S. In DSP and TDM it starts immediately after the last bit of the first slot.
- R4: With `cfg_slot_mode` = 1, the second slot starts `cfg_off2` bit clocks after the start of the first slot, in every format.
- R5: In right-justified format, the LSB of the first slot falls on the last bit of the first half-frame, moved later by `cfg_off1`. The half-frame is half the measured length, in bit clocks, of the previous frame.
- R6: With `cfg_swap` = 0, the first slot carries `s_left` and the second slot carries `s_right`. With `cfg_swap` = 1 the order is exchanged.
- R7: With `cfg_tri_en` = 1, `sdata_oe` is high only during bit cycles that carry slot data. With `cfg_tri_en` = 0, `sdata_oe` stays high and idle bits are 0. Whenever `sdata_oe` is low, `sdata` is 0. Out of reset, `sdata_oe`, `sdata` and `fsync` are all 0.
- R8: With `cfg_tri_en` = 1 and `cfg_early` = 1, `sdata_oe` drops at the `bit_mid` of each slot's LSB cycle.
- R9: Setting `cfg_slot_off[0]` removes the first slot and `cfg_slot_off[1]` removes the second slot. This applies in left-justified, I2S and DSP formats only. In right-justified and TDM, `cfg_slot_off` has no effect.
- R10: `fsync` is a one-clock pulse in the bit cycle where the first slot starts. If the first slot is off, the pulse marks the start of the second slot. If both slots are off, it marks bit 0 of the frame.
- R11: A sample pair taken over the valid/ready port goes out in the frame that starts after the transfer. `s_ready` is low from the transfer until that frame starts. A frame with no new pair repeats the previous pair.
- R12: A one-bit pulse on `wclk` and a square-wave `wclk` produce the same frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_lead | input | 1 | One-clock strobe at the start of each bit cycle |
| bit_mid | input | 1 | One-clock strobe in the middle of each bit cycle |
| wclk | input | 1 | Word clock level, sampled on `bit_lead` |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding register free |
| s_left | input | 32 | Left sample, MSB-aligned |
| s_right | input | 32 | Right sample, MSB-aligned |
| cfg_fmt | input | 3 | Framing format code |
| cfg_wlen | input | 2 | Word length code |
| cfg_off1 | input | OFS_W | First-slot offset in bit clocks |
| cfg_off2 | input | OFS_W | Second-slot delay when slot mode is on |
| cfg_slot_mode | input | 1 | Independent second-slot offset |
| cfg_swap | input | 1 | Exchange channel order |
| cfg_slot_off | input | 2 | Per-slot disable |
| cfg_tri_en | input | 1 | Release line when idle |
| cfg_early | input | 1 | Release half a bit early |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Output enable for the pad |
| fsync | output | 1 | Filter-sync pulse |

## Verification
The assertions take four things for granted about the inputs. `bit_lead` and `bit_mid` are single-clock strobes that are never adjacent. They alternate, so exactly one `bit_mid` falls inside each bit cycle. The configuration stays constant for the whole of any frame whose output matters. The stimulus meets these by generating a four-clock bit cycle, with `bit_lead` and `bit_mid` at fixed phases. Each configuration change is applied part-way through a frame that is not checked, and the comparison waits until a later frame that ran entirely under the new settings.

// File: rtl/astx_pkg.sv
package astx_pkg;

  typedef enum logic [2:0] {
    FMT_LJ  = 3'd0,
    FMT_RJ  = 3'd1,
    FMT_I2S = 3'd2,
    FMT_DSP = 3'd3,
    FMT_TDM = 3'd4
  } fmt_e;

  // Word-length code to bit count.
  function automatic logic [5:0] wl_bits(input logic [1:0] code);
    case (code)
      2'd0:    wl_bits = 6'd16;
      2'd1:    wl_bits = 6'd20;
      2'd2:    wl_bits = 6'd24;
      default: wl_bits = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/astx_frame_timer.sv
module astx_frame_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_lead,
  input  logic             wclk,
  output logic             frame_start,
  output logic [CNT_W-1:0] np,
  output logic [CNT_W-1:0] half
);
  localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

  logic             wclk_q;
  logic [CNT_W-1:0] bitpos;
  logic [CNT_W-1:0] frame_len;

  assign frame_start = bit_lead & wclk & ~wclk_q;
  assign np = frame_start ? '0 : ((bitpos == POS_MAX) ? POS_MAX : bitpos + 1'b1);
  assign half = frame_len >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_q    <= 1'b0;
      bitpos    <= '0;
      frame_len <= '0;
    end else if (bit_lead) begin
      wclk_q <= wclk;
      bitpos <= np;
      if (frame_start)
        frame_len <= (bitpos == POS_MAX) ? POS_MAX : bitpos + 1'b1;
    end
  end

  // R5
  half_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_start) && !$past(rst) |-> $stable(half));

endmodule

// File: rtl/astx_slot_plan.sv
module astx_slot_plan
  import astx_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int OFS_W = 8,
  localparam int SW = CNT_W + 2
) (
  input  logic [2:0]       cfg_fmt,
  input  logic [1:0]       cfg_wlen,
  input  logic [OFS_W-1:0] cfg_off1,
  input  logic [OFS_W-1:0] cfg_off2,
  input  logic             cfg_slot_mode,
  input  logic [1:0]       cfg_slot_off,
  input  logic [CNT_W-1:0] half,
  output logic [SW-1:0]    start_a,
  output logic [SW-1:0]    start_b,
  output logic [SW-1:0]    wlen,
  output logic             en_a,
  output logic             en_b,
  output logic [SW-1:0]    sync_pos
);
  fmt_e          fmt;
  logic [SW-1:0] half_e, off1_e, off2_e, rj_raw;
  logic          rj_ok, may_disable, split_half;

  always_comb begin
    fmt    = fmt_e'(cfg_fmt);
    half_e = SW'(half);
    off1_e = SW'(cfg_off1);
    off2_e = SW'(cfg_off2);
    wlen   = SW'(wl_bits(cfg_wlen));
    rj_raw = half_e + off1_e;
    rj_ok  = (rj_raw >= wlen);
    may_disable = (fmt == FMT_LJ) || (fmt == FMT_I2S) || (fmt == FMT_DSP);
    split_half  = (fmt == FMT_LJ) || (fmt == FMT_I2S) || (fmt == FMT_RJ);

    case (fmt)
      FMT_I2S: start_a = off1_e + 1'b1;
      FMT_RJ:  start_a = rj_raw - wlen;
      default: start_a = off1_e;
    endcase

    if (cfg_slot_mode)   start_b = start_a + off2_e;
    else if (split_half) start_b = start_a + half_e;
    else                 start_b = start_a + wlen;

    en_a = !(may_disable && cfg_slot_off[0]) && ((fmt != FMT_RJ) || rj_ok);
    en_b = !(may_disable && cfg_slot_off[1]) && ((fmt != FMT_RJ) || rj_ok);

    if (en_a)      sync_pos = start_a;
    else if (en_b) sync_pos = start_b;
    else           sync_pos = '0;
  end

endmodule

// File: rtl/astx_tx_core.sv
module astx_tx_core #(
  parameter int CNT_W = 9,
  parameter int SMP_W = 32,
  localparam int SW    = CNT_W + 2,
  localparam int IDX_W = $clog2(SMP_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_lead,
  input  logic             bit_mid,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] np,
  input  logic [SW-1:0]    start_a,
  input  logic [SW-1:0]    start_b,
  input  logic [SW-1:0]    wlen,
  input  logic             en_a,
  input  logic             en_b,
  input  logic [SW-1:0]    sync_pos,
  input  logic             cfg_swap,
  input  logic             cfg_tri_en,
  input  logic             cfg_early,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SMP_W-1:0] s_left,
  input  logic [SMP_W-1:0] s_right,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             fsync
);
  logic             hold_full;
  logic [SMP_W-1:0] hold_l, hold_r, sh_l, sh_r, nxt_l, nxt_r;
  logic [SW-1:0]    np_e;
  logic             lsb_q;

  logic [SW-1:0]    st   [2];
  logic             en   [2];
  logic [SMP_W-1:0] word [2];
  logic             act  [2];
  logic             bitv [2];
  logic             last [2];

  assign s_ready = !hold_full;
  assign np_e    = SW'(np);
  assign nxt_l   = (frame_start && hold_full) ? hold_l : sh_l;
  assign nxt_r   = (frame_start && hold_full) ? hold_r : sh_r;

  assign st[0]   = start_a;
  assign st[1]   = start_b;
  assign en[0]   = en_a;
  assign en[1]   = en_b;
  assign word[0] = cfg_swap ? nxt_r : nxt_l;
  assign word[1] = cfg_swap ? nxt_l : nxt_r;

  for (genvar i = 0; i < 2; i++) begin : g_slot
    logic [SW-1:0]    diff;
    logic [IDX_W-1:0] idx;
    always_comb begin
      diff    = np_e - st[i];
      idx     = IDX_W'(SMP_W - 1) - diff[IDX_W-1:0];
      act[i]  = en[i] && (np_e >= st[i]) && (diff < wlen);
      bitv[i] = word[i][idx];
      last[i] = act[i] && (diff == wlen - 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      sh_l      <= '0;
      sh_r      <= '0;
    end else if (frame_start && hold_full) begin
      sh_l      <= hold_l;
      sh_r      <= hold_r;
      hold_full <= 1'b0;
    end else if (s_valid && s_ready) begin
      hold_l    <= s_left;
      hold_r    <= s_right;
      hold_full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
      lsb_q    <= 1'b0;
      fsync    <= 1'b0;
    end else begin
      fsync <= bit_lead && (np_e == sync_pos);
      if (bit_lead) begin
        if (act[0]) begin
          sdata    <= bitv[0];
          sdata_oe <= 1'b1;
          lsb_q    <= last[0];
        end else if (act[1]) begin
          sdata    <= bitv[1];
          sdata_oe <= 1'b1;
          lsb_q    <= last[1];
        end else begin
          sdata    <= 1'b0;
          sdata_oe <= !cfg_tri_en;
          lsb_q    <= 1'b0;
        end
      end else if (bit_mid && cfg_early && cfg_tri_en && lsb_q) begin
        sdata    <= 1'b0;
        sdata_oe <= 1'b0;
      end
    end
  end

  // R7
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sdata_oe |-> !sdata);

  // R7
  drive_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bit_lead) && !$past(cfg_tri_en) && !$past(rst) |-> sdata_oe);

  // R10
  fsync_single_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |=> !fsync);

  // R10
  fsync_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |-> $past(bit_lead));

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    s_valid && s_ready |=> !s_ready);

  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_lead) && !$past(bit_mid) |-> $stable(sdata));

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx #(
  parameter int CNT_W = 9,
  parameter int OFS_W = 8,
  parameter int SMP_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_lead,
  input  logic             bit_mid,
  input  logic             wclk,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SMP_W-1:0] s_left,
  input  logic [SMP_W-1:0] s_right,
  input  logic [2:0]       cfg_fmt,
  input  logic [1:0]       cfg_wlen,
  input  logic [OFS_W-1:0] cfg_off1,
  input  logic [OFS_W-1:0] cfg_off2,
  input  logic             cfg_slot_mode,
  input  logic             cfg_swap,
  input  logic [1:0]       cfg_slot_off,
  input  logic             cfg_tri_en,
  input  logic             cfg_early,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             fsync
);
  localparam int SW = CNT_W + 2;

  logic             frame_start;
  logic [CNT_W-1:0] np, half;
  logic [SW-1:0]    start_a, start_b, wlen, sync_pos;
  logic             en_a, en_b;

  astx_frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .bit_lead(bit_lead), .wclk(wclk),
    .frame_start(frame_start), .np(np), .half(half)
  );

  astx_slot_plan #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_plan (
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_off1(cfg_off1),
    .cfg_off2(cfg_off2), .cfg_slot_mode(cfg_slot_mode),
    .cfg_slot_off(cfg_slot_off), .half(half),
    .start_a(start_a), .start_b(start_b), .wlen(wlen),
    .en_a(en_a), .en_b(en_b), .sync_pos(sync_pos)
  );

  astx_tx_core #(.CNT_W(CNT_W), .SMP_W(SMP_W)) u_core (
    .clk(clk), .rst(rst), .bit_lead(bit_lead), .bit_mid(bit_mid),
    .frame_start(frame_start), .np(np), .start_a(start_a),
    .start_b(start_b), .wlen(wlen), .en_a(en_a), .en_b(en_b),
    .sync_pos(sync_pos), .cfg_swap(cfg_swap), .cfg_tri_en(cfg_tri_en),
    .cfg_early(cfg_early), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .sdata(sdata),
    .sdata_oe(sdata_oe), .fsync(fsync)
  );

endmodule

// File: tb/audio_serial_tx_tb_top.sv
module audio_serial_tx_tb_top;
  localparam int FL   = 64;
  localparam int HALF = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        bit_lead, bit_mid, wclk;
  logic        s_valid, s_ready;
  logic [31:0] s_left, s_right;
  logic [2:0]  cfg_fmt;
  logic [1:0]  cfg_wlen;
  logic [7:0]  cfg_off1, cfg_off2;
  logic        cfg_slot_mode, cfg_swap, cfg_tri_en, cfg_early;
  logic [1:0]  cfg_slot_off;
  logic        sdata, sdata_oe, fsync;

  audio_serial_tx dut_i (
    .clk(clk), .rst(rst), .bit_lead(bit_lead), .bit_mid(bit_mid), .wclk(wclk),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_off1(cfg_off1),
    .cfg_off2(cfg_off2), .cfg_slot_mode(cfg_slot_mode), .cfg_swap(cfg_swap),
    .cfg_slot_off(cfg_slot_off), .cfg_tri_en(cfg_tri_en), .cfg_early(cfg_early),
    .sdata(sdata), .sdata_oe(sdata_oe), .fsync(fsync)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  bit sq_mode = 1'b1;
  int frame_cnt = 0;

  logic cap_d [0:FL-1];
  logic cap_o [0:FL-1];
  logic cap_l [0:FL-1];
  logic cap_f [0:FL-1];
  logic fr_d  [0:FL-1];
  logic fr_o  [0:FL-1];
  logic fr_l  [0:FL-1];
  logic fr_f  [0:FL-1];

  // Bit-cycle generator: four clocks per bit, lead at phase 0, mid at phase 2.
  initial begin
    int c;
    int p;
    c = 0; p = 0;
    bit_lead = 1'b0; bit_mid = 1'b0; wclk = 1'b0;
    forever begin
      @(negedge clk);
      case (c % 4)
        0: begin
          bit_lead = 1'b1;
          wclk = sq_mode ? (p < HALF) : (p == 0);
        end
        1: begin
          bit_lead = 1'b0;
          cap_d[p] = sdata;
          cap_o[p] = sdata_oe;
          cap_f[p] = fsync;
        end
        2: bit_mid = 1'b1;
        default: begin
          bit_mid = 1'b0;
          cap_l[p] = sdata_oe;
          if (p == FL - 1) begin
            fr_d = cap_d; fr_o = cap_o; fr_l = cap_l; fr_f = cap_f;
            frame_cnt++;
            p = 0;
          end else p++;
        end
      endcase
      c++;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int fmt, input int wl, input int o1, input int o2,
                         input bit sm, input bit sw, input int so,
                         input bit te, input bit ea);
    @(negedge clk);
    cfg_fmt = 3'(fmt); cfg_wlen = 2'(wl); cfg_off1 = 8'(o1); cfg_off2 = 8'(o2);
    cfg_slot_mode = sm; cfg_swap = sw; cfg_slot_off = 2'(so);
    cfg_tri_en = te; cfg_early = ea;
  endtask

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frame_cnt + n;
    while (frame_cnt < target) @(negedge clk);
  endtask

  // Expected frame from the requirements, compared with the last captured frame.
  task automatic check_frame(string tag, input logic [31:0] l, input logic [31:0] r);
    int w, sa, sb, fs_pos, bad_p, fs_hits, fs_at;
    bit ena, enb, dis_ok;
    logic [31:0] wa, wb;
    logic ed, eo, el, lastb;
    bit bad_d, bad_o, bad_l;
    logic ad, ao, al, xd, xo, xl;
    case (cfg_wlen) 0: w = 16; 1: w = 20; 2: w = 24; default: w = 32; endcase
    dis_ok = (cfg_fmt == 0) || (cfg_fmt == 2) || (cfg_fmt == 3);
    case (cfg_fmt)
      2: sa = int'(cfg_off1) + 1;
      1: sa = HALF + int'(cfg_off1) - w;
      default: sa = int'(cfg_off1);
    endcase
    if (cfg_slot_mode) sb = sa + int'(cfg_off2);
    else if (cfg_fmt <= 2) sb = sa + HALF;
    else sb = sa + w;
    ena = !(dis_ok && cfg_slot_off[0]);
    enb = !(dis_ok && cfg_slot_off[1]);
    wa = cfg_swap ? r : l;
    wb = cfg_swap ? l : r;
    fs_pos = ena ? sa : (enb ? sb : 0);
    bad_d = 0; bad_o = 0; bad_l = 0;
    ad = 0; ao = 0; al = 0; xd = 0; xo = 0; xl = 0; bad_p = 0;
    fs_hits = 0; fs_at = -1;
    for (int p = 0; p < FL; p++) begin
      ed = 1'b0; eo = !cfg_tri_en; lastb = 1'b0;
      if (ena && p >= sa && p < sa + w) begin
        ed = wa[31 - (p - sa)]; eo = 1'b1; lastb = (p == sa + w - 1);
      end else if (enb && p >= sb && p < sb + w) begin
        ed = wb[31 - (p - sb)]; eo = 1'b1; lastb = (p == sb + w - 1);
      end
      el = (cfg_tri_en && cfg_early && lastb) ? 1'b0 : eo;
      if (!bad_d && fr_d[p] !== ed) begin bad_d = 1; ad = fr_d[p]; xd = ed; bad_p = p; end
      if (!bad_o && fr_o[p] !== eo) begin bad_o = 1; ao = fr_o[p]; xo = eo; end
      if (!bad_l && fr_l[p] !== el) begin bad_l = 1; al = fr_l[p]; xl = el; end
      if (fr_f[p] === 1'b1) begin fs_hits++; fs_at = p; end
    end
    checks += 4;
    if (bad_d) begin fails++; $display("FAIL %s data at bit %0d actual=%b expected=%b", tag, bad_p, ad, xd); end
    if (bad_o) begin fails++; $display("FAIL %s output enable actual=%b expected=%b", tag, ao, xo); end
    if (bad_l) begin fails++; $display("FAIL %s mid-bit enable actual=%b expected=%b", tag, al, xl); end
    if (fs_hits != 1 || fs_at != fs_pos) begin
      fails++;
      $display("FAIL %s fsync actual=%0d(x%0d) expected=%0d", tag, fs_at, fs_hits, fs_pos);
    end
  endtask

  task automatic run_case(string tag, input logic [31:0] l, input logic [31:0] r);
    push(l, r);
    wait_frames(2);
    check_frame(tag, l, r);
  endtask

  task automatic t_reset();
    rst = 1'b1; s_valid = 1'b0; s_left = '0; s_right = '0;
    cfg_fmt = 3'd0; cfg_wlen = 2'd0; cfg_off1 = '0; cfg_off2 = '0;
    cfg_slot_mode = 0; cfg_swap = 0; cfg_slot_off = 0; cfg_tri_en = 0; cfg_early = 0;
    repeat (10) @(negedge clk);
    check_bit("R7 reset sdata_oe", sdata_oe, 1'b0);
    check_bit("R7 reset sdata", sdata, 1'b0);
    check_bit("R10 reset fsync", fsync, 1'b0);
    check_bit("R11 reset s_ready", s_ready, 1'b1);
    rst = 1'b0;
    wait_frames(2);
  endtask

  task automatic t_left_just();
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_case("R1 R2 R3 R7 R10 left-justified 16", 32'hA5C3_1234, 32'h5A3C_8765);
  endtask

  task automatic t_i2s();
    set_cfg(2, 2, 0, 0, 0, 0, 0, 1, 0);
    run_case("R2 R3 I2S 24", 32'hC001_D00D, 32'h1357_9BDF);
  endtask

  task automatic t_dsp();
    set_cfg(3, 1, 3, 0, 0, 0, 0, 1, 0);
    run_case("R3 R7 DSP 20 offset 3", 32'hF0E1_D2C3, 32'h0F1E_2D3C);
  endtask

  task automatic t_tdm_slots();
    set_cfg(4, 0, 5, 40, 1, 1, 0, 1, 0);
    run_case("R4 R6 TDM slot mode swapped", 32'hBEEF_0000, 32'h8001_0000);
  endtask

  task automatic t_right_just();
    set_cfg(1, 2, 0, 0, 0, 0, 0, 1, 0);
    run_case("R5 right-justified 24", 32'h9ABC_DEF0, 32'h2468_ACE0);
  endtask

  task automatic t_early();
    set_cfg(3, 3, 0, 0, 0, 0, 0, 1, 1);
    run_case("R8 early release DSP 32", 32'h8000_0001, 32'h7FFF_FFFE);
  endtask

  task automatic t_disable();
    set_cfg(0, 0, 0, 0, 0, 0, 1, 1, 0);
    run_case("R9 R10 left-justified first slot off", 32'hFFFF_0000, 32'hA0A0_0000);
    set_cfg(3, 0, 2, 0, 0, 0, 3, 1, 0);
    run_case("R9 R10 DSP both slots off", 32'h1234_5678, 32'h8765_4321);
    set_cfg(4, 0, 0, 0, 0, 0, 3, 1, 0);
    run_case("R9 TDM disable ignored", 32'h3C3C_0000, 32'hC3C3_0000);
  endtask

  task automatic t_pulse();
    sq_mode = 1'b0;
    set_cfg(3, 2, 2, 0, 0, 0, 0, 1, 0);
    run_case("R12 pulse word clock", 32'h6B6B_6B00, 32'h9494_9400);
    sq_mode = 1'b1;
    set_cfg(3, 2, 2, 0, 0, 0, 0, 1, 0);
    run_case("R12 square word clock", 32'h6B6B_6B00, 32'h9494_9400);
  endtask

  task automatic t_backpressure();
    set_cfg(0, 0, 0, 0, 0, 0, 0, 1, 0);
    wait_frames(1);
    push(32'h1111_0000, 32'h2222_0000);
    check_bit("R11 ready low while holding", s_ready, 1'b0);
    push(32'h4444_0000, 32'h8888_0000);
    wait_frames(1);
    check_frame("R11 first pair in next frame", 32'h1111_0000, 32'h2222_0000);
    wait_frames(1);
    check_frame("R11 second pair after stall", 32'h4444_0000, 32'h8888_0000);
    wait_frames(1);
    check_frame("R11 pair repeated without update", 32'h4444_0000, 32'h8888_0000);
  endtask

  initial begin
    t_reset();
    t_left_just();
    t_i2s();
    t_dsp();
    t_tdm_slots();
    t_right_just();
    t_early();
    t_disable();
    t_pulse();
    t_backpressure();
    finish_run();
  end

endmodule